// File: doc/BRIEF.md
# Error-Correcting Word Memory Controller

This controller connects a 32-bit bus master to a single-port storage array whose every entry holds one data word together with seven check bits. On each array write it generates the check bits; on each array read it recomputes the syndrome, repairs a one-bit flip and flags a two-bit flip. The master sees a simple request/ready handshake. It holds `req_i` and its qualifiers steady until it samples `ready_o` high at a rising clock edge. Every cycle the master waits with `req_i` high and `ready_o` low counts as one wait state.

A write that does not enable all four byte lanes cannot be encoded on its own. The controller therefore reads the stored word, checks and repairs it, places the enabled bytes into it and holds the result in a one-entry pending buffer. The re-encoded word goes to the array one cycle later. A write to the same address that arrives in the very next cycle is merged into that buffer without touching the array, so the master sees no wait state for it. Any other access, or an idle cycle, drains the buffer to the array first. After power-up the check bits are arbitrary, so each location must receive a full-word write before it is read or partially written.

The storage array sits outside the block. It has a one-cycle read latency: data requested in one cycle appears on `mem_rdata_i` in the next cycle.

Top module: `ecc_sram_ctrl`

## Requirements
- R1: A write with all four byte enables set and no pending buffer entry stores its word in the same cycle, with 0 wait states, whether the prior cycle was idle, a read or a full write. The stored word keeps the data in bits [31:0] and the check bits in bits [38:32]. An all-zero data word gets all-zero check bits.
- R2: A read with no pending buffer entry completes after 1 wait state and returns the stored data.
- R3: A write with some byte enables clear, after an idle cycle or a full write, completes after 1 wait state. Byte lane n (bits 8n+7 to 8n) takes the new data when byte enable n is set and keeps the stored byte otherwise.
- R4: A partial write whose request directly follows the completion of a read takes 2 wait states.
- R5: A partial or full write to the pending buffer's address, in the cycle right after the buffer was loaded, takes 0 wait states. It merges into the buffered word, and that word reaches the array later.
- R6: When the buffer is occupied, a write to another address or any read first drains the buffer to the array. A full write then takes 1 wait state in total, and a partial write or a read takes 2. A cycle with no request also drains the buffer.
- R7: A stored word with one flipped bit, in the data or in the check bits, reads back as the corrected data, with `err_sgl_o` high in the completion cycle.
- R8: A stored word with two flipped bits raises `err_dbl_o` in the completion cycle. This includes a never-written location holding a data pattern two bits away from zero with zero check bits.
- R9: A partial write whose internal read finds an uncorrectable word completes with `err_dbl_o` high and leaves the stored word exactly as it was.
- R10: A partial write whose internal read finds a one-bit error raises `err_sgl_o` and merges the new bytes into the corrected word.
- R11: While `srst_i` is high the controller accepts no request and keeps `ready_o` low. A pending buffer entry is still written to the array.
- R12: `err_sgl_o` and `err_dbl_o` are never high together. They are high only in a cycle with `ready_o` high, and stay low on reads of clean words.
- R13: After `rst_ni` is released and with no request, `ready_o`, `mem_en_o` and both error outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| srst_i | input | 1 | Synchronous quiesce request, honoured at access boundaries |
| req_i | input | 1 | Bus request, held until ready |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Word address |
| be_i | input | 4 | Byte enables, bit n for bits 8n+7..8n |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Corrected read data, valid with ready on reads |
| ready_o | output | 1 | Access completes at this edge |
| err_sgl_o | output | 1 | Corrected single-bit error in the completing access |
| err_dbl_o | output | 1 | Uncorrectable error in the completing access |
| mem_en_o | output | 1 | Array access enable |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | AW | Array address |
| mem_wdata_o | output | 39 | Encoded word to the array |
| mem_rdata_i | input | 39 | Encoded word from the array, one cycle after a read |

## Verification
The bench targets the wait-state counts that depend on what came before. The hardest cases are a partial write right after a read, back-to-back writes to one address, and a different access arriving while the pending buffer is full. A controller that mishandles the turnaround or the forwarding shows a wrong wait count or returns stale bytes on the next read. It also injects one-bit and two-bit flips directly into the array, in both data and check bits. A missing correction returns corrupt data, and a write-back after a failed check changes the stored word when it must stay unchanged. A quiesce applied while the buffer is full checks that the buffered word still reaches the array instead of being lost.

// File: rtl/ecc_sram_pkg.sv
package ecc_sram_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BE_W   = DATA_W / BYTE_W;
  localparam int unsigned HAM_W  = 6;
  localparam int unsigned CHK_W  = HAM_W + 1;
  localparam int unsigned CW_W   = DATA_W + CHK_W;
  localparam int unsigned CW_POS = DATA_W + HAM_W;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_MRG} ctrl_state_e;

  function automatic bit is_pow2(input int unsigned v);
    return (v & (v - 1)) == 0;
  endfunction

  // Hamming positions 1..CW_POS; check bits at powers of two.
  function automatic logic [CW_POS:1] spread(input logic [CW_W-1:0] w, input bit with_chk);
    logic [CW_POS:1] cw;
    int unsigned k;
    cw = '0;
    k = 0;
    for (int unsigned pos = 1; pos <= CW_POS; pos++) begin
      if (!is_pow2(pos)) begin
        cw[pos] = w[k];
        k++;
      end else if (with_chk) begin
        for (int unsigned i = 0; i < HAM_W; i++)
          if (pos == (32'd1 << i)) cw[pos] = w[DATA_W+i];
      end
    end
    return cw;
  endfunction

  function automatic logic [HAM_W-1:0] fold(input logic [CW_POS:1] cw);
    logic [HAM_W-1:0] s;
    s = '0;
    for (int unsigned i = 0; i < HAM_W; i++)
      for (int unsigned pos = 1; pos <= CW_POS; pos++)
        if (((pos >> i) & 32'd1) != 0) s[i] = s[i] ^ cw[pos];
    return s;
  endfunction

  function automatic logic [CW_W-1:0] secded_enc(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] p;
    p = fold(spread({{CHK_W{1'b0}}, d}, 1'b0));
    return {^{p, d}, p, d};
  endfunction

  function automatic logic [HAM_W-1:0] secded_syn(input logic [CW_W-1:0] w);
    return fold(spread(w, 1'b1));
  endfunction

  function automatic logic [DATA_W-1:0] secded_flip(input logic [HAM_W-1:0] syn);
    logic [DATA_W-1:0] m;
    int unsigned k;
    m = '0;
    k = 0;
    for (int unsigned pos = 1; pos <= CW_POS; pos++) begin
      if (!is_pow2(pos)) begin
        if (pos == 32'(syn)) m[k] = 1'b1;
        k++;
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/ecc_sram_enc.sv
module ecc_sram_enc
  import ecc_sram_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CW_W-1:0]   cw_o
);
  assign cw_o = secded_enc(data_i);
endmodule

// File: rtl/ecc_sram_dec.sv
module ecc_sram_dec
  import ecc_sram_pkg::*;
(
  input  logic [CW_W-1:0]   cw_i,
  output logic [DATA_W-1:0] data_o,
  output logic              sgl_o,
  output logic              dbl_o
);
  logic [HAM_W-1:0] syn;
  logic             par;
  logic             in_rng;

  assign syn    = secded_syn(cw_i);
  assign par    = ^cw_i;
  assign in_rng = 32'(syn) <= CW_POS;
  // odd overall parity = one flip (syn 0 means the overall bit itself)
  assign sgl_o  = par && in_rng;
  assign dbl_o  = (!par && (syn != '0)) || (par && !in_rng);
  assign data_o = cw_i[DATA_W-1:0] ^ (sgl_o ? secded_flip(syn) : '0);
endmodule

// File: rtl/ecc_sram_merge.sv
module ecc_sram_merge
  import ecc_sram_pkg::*;
(
  input  logic [DATA_W-1:0] base_i,
  input  logic [DATA_W-1:0] new_i,
  input  logic [BE_W-1:0]   be_i,
  output logic [DATA_W-1:0] data_o
);
  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign data_o[BYTE_W*g +: BYTE_W] = be_i[g] ? new_i[BYTE_W*g +: BYTE_W]
                                                : base_i[BYTE_W*g +: BYTE_W];
  end
endmodule

// File: rtl/ecc_sram_ctrl.sv
module ecc_sram_ctrl
  import ecc_sram_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o,
  output logic              err_sgl_o,
  output logic              err_dbl_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [CW_W-1:0]   mem_wdata_o,
  input  logic [CW_W-1:0]   mem_rdata_i
);
  ctrl_state_e       state_q, state_d;
  logic              prev_rd_q;
  logic              pend_vld_q;
  logic [AW-1:0]     pend_addr_q;
  logic [DATA_W-1:0] pend_data_q;
  logic [DATA_W-1:0] mrg_base, mrg_out, enc_in, dec_data;
  logic              dec_sgl, dec_dbl;
  logic              pend_ld, pend_clr;
  logic              can_go, hit, full_wr, busy;

  assign can_go  = req_i && !srst_i;
  assign hit     = pend_vld_q && (addr_i == pend_addr_q);
  assign full_wr = &be_i;
  assign busy    = state_q != S_IDLE;

  assign mrg_base = (state_q == S_MRG) ? dec_data : pend_data_q;

  ecc_sram_merge i_merge (
    .base_i (mrg_base),
    .new_i  (wdata_i),
    .be_i   (be_i),
    .data_o (mrg_out)
  );

  ecc_sram_enc i_enc (
    .data_i (enc_in),
    .cw_o   (mem_wdata_o)
  );

  ecc_sram_dec i_dec (
    .cw_i   (mem_rdata_i),
    .data_o (dec_data),
    .sgl_o  (dec_sgl),
    .dbl_o  (dec_dbl)
  );

  always_comb begin
    state_d    = state_q;
    ready_o    = 1'b0;
    mem_en_o   = 1'b0;
    mem_we_o   = 1'b0;
    mem_addr_o = addr_i;
    enc_in     = wdata_i;
    pend_ld    = 1'b0;
    pend_clr   = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (can_go && we_i && hit) begin
          ready_o = 1'b1;            // forward into pending word
          pend_ld = 1'b1;
        end else if (pend_vld_q) begin
          mem_en_o   = 1'b1;         // drain pending word first
          mem_we_o   = 1'b1;
          mem_addr_o = pend_addr_q;
          enc_in     = pend_data_q;
          pend_clr   = 1'b1;
        end else if (can_go) begin
          if (we_i && full_wr) begin
            mem_en_o = 1'b1;
            mem_we_o = 1'b1;
            ready_o  = 1'b1;
          end else if (!(we_i && prev_rd_q)) begin
            mem_en_o = 1'b1;
            state_d  = we_i ? S_MRG : S_RD;
          end
          // else: turnaround cycle after a read
        end
      end
      S_RD: begin
        ready_o = 1'b1;
        state_d = S_IDLE;
      end
      S_MRG: begin
        ready_o = 1'b1;
        state_d = S_IDLE;
        pend_ld = !dec_dbl;          // abort on uncorrectable word
      end
      default: state_d = S_IDLE;
    endcase
  end

  assign rdata_o   = (state_q == S_RD) ? dec_data : '0;
  assign err_sgl_o = busy && dec_sgl;
  assign err_dbl_o = busy && dec_dbl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      prev_rd_q   <= 1'b0;
      pend_vld_q  <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
    end else begin
      state_q   <= state_d;
      prev_rd_q <= state_q == S_RD;
      if (pend_ld) begin
        pend_vld_q  <= 1'b1;
        pend_addr_q <= addr_i;
        pend_data_q <= mrg_out;
      end else if (pend_clr) begin
        pend_vld_q <= 1'b0;
      end
    end
  end

  AST_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({err_sgl_o, err_dbl_o})); // R12
  AST_ERR_WITH_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_sgl_o || err_dbl_o) |-> ready_o); // R12
  AST_DBL_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_MRG && err_dbl_o) |=> !pend_vld_q); // R9
  AST_SRST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srst_i && state_q == S_IDLE) |-> !ready_o); // R11
  AST_DATA_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> $past(mem_en_o && !mem_we_o)); // R2
  AST_IDLE_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_vld_q && !req_i && state_q == S_IDLE) |-> (mem_we_o && mem_addr_o == pend_addr_q)); // R6
  AST_PEND_AFTER_MRG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_MRG && !err_dbl_o) |=> pend_vld_q); // R3
endmodule

// File: tb/test_ecc_sram_ctrl.sv
`timescale 1ns/1ps
module test_ecc_sram_ctrl;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0, rst_n = 1'b0, srst = 1'b0, req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [3:0]    be = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata_o;
  logic          ready_o, err_sgl_o, err_dbl_o;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [38:0]   mem_wdata, mem_rq;
  logic [38:0]   mem [DEPTH];

  logic [31:0] ref_m [16];
  int n_chk = 0, n_err = 0;
  int kind = 0;              // 0 none, 1 read just done, 2 pending partial
  logic [AW-1:0] last_a = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ecc_sram_ctrl #(.AW(AW)) i_ecc_sram_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .srst_i(srst), .req_i(req), .we_i(we),
    .addr_i(addr), .be_i(be), .wdata_i(wdata), .rdata_o(rdata_o),
    .ready_o(ready_o), .err_sgl_o(err_sgl_o), .err_dbl_o(err_dbl_o),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rq)
  );

  always @(posedge clk) begin
    if (mem_en && mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_en && !mem_we) mem_rq <= mem[mem_addr];
  end

  function automatic logic [31:0] merge_f(input logic [31:0] b, d, input logic [3:0] e);
    logic [31:0] r;
    r = b;
    for (int i = 0; i < 4; i++) if (e[i]) r[8*i +: 8] = d[8*i +: 8];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    req = 1'b0;
    we  = 1'b0;
    if (n > 0) kind = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_op(input logic w, input logic [AW-1:0] a, input logic [3:0] b,
                        input logic [31:0] d, output logic [31:0] rd, output int ws,
                        output logic sg, output logic db);
    req = 1'b1; we = w; addr = a; be = b; wdata = d; ws = 0;
    #1;
    while (!ready_o && ws < 40) begin
      ws++;
      @(negedge clk);
      #1;
    end
    rd = rdata_o; sg = err_sgl_o; db = err_dbl_o;
    @(negedge clk);
  endtask

  task automatic do_op(input string tag, input logic w, input logic [AW-1:0] a,
                       input logic [3:0] b, input logic [31:0] d, input bit aborted,
                       output logic [31:0] rd, output logic sg, output logic db);
    int ws, exp_ws;
    bit full;
    full = (b == 4'hF);
    if (kind == 2) exp_ws = (w && a == last_a) ? 0 : ((w && full) ? 1 : 2);
    else if (w && full) exp_ws = 0;
    else if (w && kind == 1) exp_ws = 2;
    else exp_ws = 1;
    bus_op(w, a, b, d, rd, ws, sg, db);
    check(ws == exp_ws, {tag, " waits"}, 64'(ws), 64'(exp_ws));
    if (!w) kind = 1;
    else if (kind == 2 && a == last_a) kind = 2;
    else if (full || aborted) kind = 0;
    else kind = 2;
    last_a = a;
    if (w && !aborted && a < 16) ref_m[a[3:0]] = merge_f(ref_m[a[3:0]], d, b);
  endtask

  task automatic rd_chk(input string tag, input logic [AW-1:0] a);
    logic [31:0] rd; logic sg, db;
    do_op(tag, 1'b0, a, 4'hF, 32'h0, 1'b0, rd, sg, db);
    check(rd == ref_m[a[3:0]], {tag, " data"}, 64'(rd), 64'(ref_m[a[3:0]]));
    check(!sg && !db, {tag, " R12 flags"}, {62'b0, sg, db}, 64'h0);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd; logic sg, db;
    logic [38:0] saved;
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) mem[i] = {7'($urandom), $urandom};
    for (int i = 0; i < 16; i++) ref_m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(!ready_o && !mem_en && !err_sgl_o && !err_dbl_o, "R13 reset state",
          {60'b0, ready_o, mem_en, err_sgl_o, err_dbl_o}, 64'h0);
    @(negedge clk);

    // full-word initialisation, back to back
    for (int i = 0; i < 16; i++) begin
      logic [31:0] v;
      v = (i == 5) ? 32'h0 : 32'hA5A5_0000 + 32'(i) * 32'h0101_0101;
      do_op("R1 init", 1'b1, AW'(i), 4'hF, v, 1'b0, rd, sg, db);
    end
    check(mem[0][31:0] == ref_m[0], "R1 layout", 64'(mem[0][31:0]), 64'(ref_m[0]));
    check(mem[5] == 39'h0, "R1 zero word", 64'(mem[5]), 64'h0);
    idle(2);

    rd_chk("R2 read", 1);
    rd_chk("R2 read b2b", 2);
    do_op("R4 part after rd", 1'b1, 3, 4'b0010, 32'h0000_7700, 1'b0, rd, sg, db);
    do_op("R5 fwd part", 1'b1, 3, 4'b1000, 32'h9900_0000, 1'b0, rd, sg, db);
    do_op("R5 fwd part2", 1'b1, 3, 4'b0001, 32'h0000_0042, 1'b0, rd, sg, db);
    rd_chk("R6 read drains", 4);
    do_op("R1 full after rd", 1'b1, 4, 4'hF, 32'h1234_5678, 1'b0, rd, sg, db);
    idle(1);
    rd_chk("R5 merged", 3);
    rd_chk("R1 full readback", 4);
    idle(1);

    do_op("R3 part after idle", 1'b1, 6, 4'b0110, 32'h00BE_EF00, 1'b0, rd, sg, db);
    do_op("R6 part other addr", 1'b1, 7, 4'b0001, 32'h0000_00C3, 1'b0, rd, sg, db);
    do_op("R6 full other addr", 1'b1, 8, 4'hF, 32'hCAFE_F00D, 1'b0, rd, sg, db);
    do_op("R3 part after full", 1'b1, 9, 4'b1100, 32'h5A5A_0000, 1'b0, rd, sg, db);
    idle(2);
    check(mem[7][31:0] == ref_m[7], "R6 drained", 64'(mem[7][31:0]), 64'(ref_m[7]));
    check(mem[9][31:0] == ref_m[9], "R6 idle drain", 64'(mem[9][31:0]), 64'(ref_m[9]));
    rd_chk("R3 merged lanes", 6);

    // single-bit errors
    idle(1);
    mem[9][13] = ~mem[9][13];
    do_op("R7 data flip", 1'b0, 9, 4'hF, 32'h0, 1'b0, rd, sg, db);
    check(rd == ref_m[9], "R7 corrected", 64'(rd), 64'(ref_m[9]));
    check(sg && !db, "R7 flag", {62'b0, sg, db}, 64'h2);
    mem[10][35] = ~mem[10][35];
    idle(1);
    do_op("R7 chk flip", 1'b0, 10, 4'hF, 32'h0, 1'b0, rd, sg, db);
    check(rd == ref_m[10] && sg && !db, "R7 check-bit flip", {rd, 30'b0, sg, db},
          {ref_m[10], 32'h2});

    // double-bit errors
    idle(1);
    mem[11][0]  = ~mem[11][0];
    mem[11][20] = ~mem[11][20];
    do_op("R8 read", 1'b0, 11, 4'hF, 32'h0, 1'b0, rd, sg, db);
    check(db && !sg, "R8 flag", {62'b0, sg, db}, 64'h1);
    idle(1);
    saved = mem[11];
    do_op("R9 part dbl", 1'b1, 11, 4'b0001, 32'h0000_00FF, 1'b1, rd, sg, db);
    check(db && !sg, "R9 flag", {62'b0, sg, db}, 64'h1);
    idle(2);
    check(mem[11] == saved, "R9 unchanged", 64'(mem[11]), 64'(saved));
    mem[20] = {7'h0, 32'h0000_0003};
    do_op("R8 powerup", 1'b0, 20, 4'hF, 32'h0, 1'b0, rd, sg, db);
    check(db, "R8 powerup flag", {63'b0, db}, 64'h1);

    // single error under partial write
    idle(1);
    mem[13][5] = ~mem[13][5];
    do_op("R10 part sgl", 1'b1, 13, 4'b0100, 32'h00EE_0000, 1'b0, rd, sg, db);
    check(sg && !db, "R10 flag", {62'b0, sg, db}, 64'h2);
    idle(2);
    rd_chk("R10 merged corrected", 13);

    // quiesce with a pending word
    idle(1);
    do_op("R11 setup", 1'b1, 14, 4'b0010, 32'h0000_3C00, 1'b0, rd, sg, db);
    srst = 1'b1; req = 1'b1; we = 1'b0; addr = 15; be = 4'hF;
    for (int c = 0; c < 3; c++) begin
      #1;
      check(!ready_o, "R11 ready low", {63'b0, ready_o}, 64'h0);
      @(negedge clk);
    end
    srst = 1'b0;
    idle(1);
    check(mem[14][31:0] == ref_m[14], "R11 drain kept", 64'(mem[14][31:0]), 64'(ref_m[14]));
    rd_chk("R11 after quiesce", 15);

    // constrained random on a small clean address set
    idle(1);
    for (int it = 0; it < 300; it++) begin
      logic w; logic [AW-1:0] a; logic [3:0] b; logic [31:0] d;
      a = AW'($urandom % 4);
      w = 1'($urandom % 2);
      b = ($urandom % 3 == 0) ? 4'hF : 4'(($urandom % 15) + 1);
      d = $urandom;
      if ($urandom % 4 == 0) idle(1);
      if (w) begin
        do_op(b == 4'hF ? "R1 rnd full" : "R3 rnd part", 1'b1, a, b, d, 1'b0, rd, sg, db);
        check(!sg && !db, "R12 rnd wr flags", {62'b0, sg, db}, 64'h0);
      end else begin
        rd_chk("R2 rnd read", a);
      end
    end
    idle(2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule